// File: doc/BRIEF.md
# IDE PIO cycle timing sequencer

This block times programmed-I/O data-port accesses on two IDE channels. Channel 0 is the primary and channel 1 the secondary. Each channel has its own sequencer. A sequencer takes a request that names the target drive and the direction. It then drives the matching active-low read or write strobe for a programmed number of clocks and samples the drive's IORDY line. When the access ends it gives a one-clock completion pulse. It then enforces a minimum recovery gap before it accepts the next request.

Each channel's timing is a pair of 2-bit codes. One code sets the clocks from strobe assertion to the first IORDY sample. The other sets the recovery clocks. A larger code gives fewer clocks. An 8-bit read/write configuration register holds the drive-1 codes for both channels. Drive-1 codes are used only when the request targets drive 1 and that channel's drive-1 enable input is set. In every other case the channel's drive-0 code pair, supplied on an input, is used.

Top module: `ide_pio_timer`

## Requirements
- R1: The configuration register reads 00h after reset. A write (cfgWe high at a clock edge) shows on cfgRdata from the next cycle.
- R2: Code selection: drive-1 codes are taken from the register when reqDrive is 1 and drv1En for that channel is 1. Channel 0 uses bits [3:0] and channel 1 uses bits [7:4]. Otherwise the channel's nibble of d0Timing is used. In each nibble, bits [3:2] are the sample code and bits [1:0] the recovery code.
- R3: With IORDY high, the strobe is low for exactly 5, 4 or 3 clocks for sample codes 00, 01 and 10. The strobe asserts in the cycle after the request is accepted.
- R4: Sample code 11 acts as 3 clocks, and rsvdErr is high together with that access's done pulse. rsvdErr stays low for every other code.
- R5: Recovery codes 00, 01, 10 and 11 give 4, 3, 2 and 1 clocks. reqReady rises that many cycles after the strobe releases, counting the first released cycle as 1. A request is accepted in any cycle where reqReady is high.
- R6: If IORDY is low at a sample edge, the strobe stays low and IORDY is sampled again at every following edge. The strobe releases after the first edge that sees IORDY high.
- R7: done is high for exactly one cycle, the first cycle after the strobe releases, and both strobes are high in that cycle.
- R8: The two channels run independently. A busy channel drops reqReady while the other channel still accepts requests and asserts its strobe.
- R9: A read drives only iorN low and a write drives only iowN low. The two are never low together on one channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration register write enable |
| cfgWdata | input | 8 | Configuration write data |
| cfgRdata | output | 8 | Configuration register contents |
| drv1En | input | 2 | Per-channel drive-1 timing enable |
| d0Timing | input | 8 | Per-channel drive-0 code pairs, nibble per channel |
| reqValid | input | 2 | Per-channel access request |
| reqDrive | input | 2 | Target drive of the request (1 = drive 1) |
| reqWrite | input | 2 | Direction of the request (1 = write) |
| reqReady | output | 2 | Channel can accept a request this cycle |
| iordy | input | 2 | Per-channel IORDY from the drives |
| iorN | output | 2 | Active-low read strobe |
| iowN | output | 2 | Active-low write strobe |
| done | output | 2 | One-cycle completion pulse |
| rsvdErr | output | 2 | Reserved sample code used, valid with done |

## Verification
A request presented before a clock edge gives a low strobe from the next cycle on. The strobe width is therefore max(sample clocks, IORDY-low cycles). done and rsvdErr are due in the first cycle with the strobe high. reqReady is due recovery-count cycles after that cycle, counted from 1. The bench drives inputs on falling edges and reads outputs on falling edges only. It measures each width by counting falling edges and compares the result with the count derived from the code tables. A register write is read back one cycle after its edge.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;
  localparam int CNT_W = 3;

  typedef struct packed {
    logic load;     // capture codes and start the strobe count
    logic restart;  // start the recovery count
    logic count;    // advance the count
  } dpCmd_t;

  function automatic logic [CNT_W-1:0] sampleClocks(input logic [1:0] code);
    case (code)
      2'b00:   sampleClocks = CNT_W'(5);
      2'b01:   sampleClocks = CNT_W'(4);
      default: sampleClocks = CNT_W'(3);  // 10, and reserved 11
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] recovClocks(input logic [1:0] code);
    recovClocks = CNT_W'(4) - CNT_W'(code);
  endfunction
endpackage

// File: rtl/ide_pio_dp.sv
module ide_pio_dp
  import ide_pio_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpCmd_t     cmd,
  input  logic [3:0] codes,
  output logic       sampleHit,
  output logic       recovHit,
  output logic       rsvdFlag
);
  logic [CNT_W-1:0] sampLim, recLim, cnt;
  logic             rsvdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampLim <= '0;
      recLim  <= '0;
      cnt     <= '0;
      rsvdQ   <= 1'b0;
    end else if (cmd.load) begin
      sampLim <= sampleClocks(codes[3:2]);
      recLim  <= recovClocks(codes[1:0]);
      rsvdQ   <= (codes[3:2] == 2'b11);
      cnt     <= CNT_W'(1);
    end else if (cmd.restart) begin
      cnt <= CNT_W'(1);
    end else if (cmd.count && cnt != '1) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign sampleHit = (cnt >= sampLim);
  assign recovHit  = (cnt >= recLim);
  assign rsvdFlag  = rsvdQ;
endmodule

// File: rtl/ide_pio_ctrl.sv
module ide_pio_ctrl
  import ide_pio_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   reqWrite,
  input  logic   iordy,
  input  logic   sampleHit,
  input  logic   recovHit,
  output dpCmd_t cmd,
  output logic   ready,
  output logic   iorN,
  output logic   iowN,
  output logic   done
);
  typedef enum logic [1:0] {IDLE, STROBE, RECOV} state_t;
  state_t stateQ, stateD;
  logic   writeQ, doneQ, accept, release_;

  assign ready    = (stateQ == IDLE) || (stateQ == RECOV && recovHit);
  assign accept   = reqValid && ready;
  assign release_ = (stateQ == STROBE) && sampleHit && iordy;

  always_comb begin
    stateD = stateQ;
    cmd    = '0;
    case (stateQ)
      IDLE: if (accept) begin
        stateD   = STROBE;
        cmd.load = 1'b1;
      end
      STROBE: if (release_) begin
        stateD      = RECOV;
        cmd.restart = 1'b1;
      end else if (!sampleHit) begin
        cmd.count = 1'b1;
      end
      RECOV: if (accept) begin
        stateD   = STROBE;
        cmd.load = 1'b1;
      end else if (recovHit) begin
        stateD = IDLE;
      end else begin
        cmd.count = 1'b1;
      end
      default: stateD = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= IDLE;
      writeQ <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= release_;
      if (accept) writeQ <= reqWrite;
    end
  end

  assign iorN = !((stateQ == STROBE) && !writeQ);
  assign iowN = !((stateQ == STROBE) && writeQ);
  assign done = doneQ;

  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(!iorN && !iowN));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_released_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (iorN && iowN));
  assert_min_width_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!(iorN && iowN) && !sampleHit) |=> !(iorN && iowN));
  assert_iordy_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!(iorN && iowN) && !iordy) |=> (!(iorN && iowN) && !done));
  assert_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(iorN && iowN) |-> !ready);
endmodule

// File: rtl/ide_pio_timer.sv
module ide_pio_timer
  import ide_pio_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [4*NUM_CH-1:0] cfgWdata,
  output logic [4*NUM_CH-1:0] cfgRdata,
  input  logic [NUM_CH-1:0]   drv1En,
  input  logic [4*NUM_CH-1:0] d0Timing,
  input  logic [NUM_CH-1:0]   reqValid,
  input  logic [NUM_CH-1:0]   reqDrive,
  input  logic [NUM_CH-1:0]   reqWrite,
  output logic [NUM_CH-1:0]   reqReady,
  input  logic [NUM_CH-1:0]   iordy,
  output logic [NUM_CH-1:0]   iorN,
  output logic [NUM_CH-1:0]   iowN,
  output logic [NUM_CH-1:0]   done,
  output logic [NUM_CH-1:0]   rsvdErr
);
  localparam int CFG_W = 4 * NUM_CH;

  logic [CFG_W-1:0] cfgQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cfgQ <= '0;
    else if (cfgWe) cfgQ <= cfgWdata;
  end
  assign cfgRdata = cfgQ;

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    dpCmd_t     cmd;
    logic [3:0] codes;
    logic       sampleHit, recovHit, rsvdFlag;

    assign codes = (reqDrive[g] && drv1En[g]) ? cfgQ[4*g +: 4] : d0Timing[4*g +: 4];

    ide_pio_dp dp_i (
      .clk(clk), .rstN(rstN), .cmd(cmd), .codes(codes),
      .sampleHit(sampleHit), .recovHit(recovHit), .rsvdFlag(rsvdFlag)
    );

    ide_pio_ctrl ctrl_i (
      .clk(clk), .rstN(rstN), .reqValid(reqValid[g]), .reqWrite(reqWrite[g]),
      .iordy(iordy[g]), .sampleHit(sampleHit), .recovHit(recovHit), .cmd(cmd),
      .ready(reqReady[g]), .iorN(iorN[g]), .iowN(iowN[g]), .done(done[g])
    );

    assign rsvdErr[g] = done[g] && rsvdFlag;

    assert_err_with_done_R4: assert property (@(posedge clk) disable iff (!rstN)
      rsvdErr[g] |-> done[g]);
  end
endmodule

// File: tb/ide_pio_timer_tb.sv
module ide_pio_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rstN = 1'b0, cfgWe = 1'b0;
  logic [7:0] cfgWdata = '0, cfgRdata, d0Timing = '0;
  logic [1:0] drv1En = '0, reqValid = '0, reqDrive = '0, reqWrite = '0;
  logic [1:0] reqReady, iordy = 2'b11, iorN, iowN, done, rsvdErr;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ide_pio_timer dut_i (.*);

  typedef struct packed {
    logic       ch, drv, en, wr;
    logic [7:0] regv;
    logic [3:0] d0;
    logic [3:0] k;   // IORDY-low strobe cycles
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 4'hF, 4'd0},
    '{1'b0, 1'b1, 1'b1, 1'b1, 8'h05, 4'hF, 4'd0},
    '{1'b0, 1'b1, 1'b1, 1'b0, 8'h0A, 4'hF, 4'd0},
    '{1'b0, 1'b1, 1'b1, 1'b0, 8'h0F, 4'h0, 4'd0},
    '{1'b0, 1'b1, 1'b0, 1'b0, 8'h0F, 4'h6, 4'd0},
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'h0F, 4'h0, 4'd0},
    '{1'b1, 1'b1, 1'b1, 1'b0, 8'hA0, 4'hF, 4'd0},
    '{1'b1, 1'b1, 1'b1, 1'b1, 8'h5F, 4'hF, 4'd0},
    '{1'b1, 1'b1, 1'b1, 1'b0, 8'hF0, 4'h0, 4'd0},
    '{1'b1, 1'b0, 1'b1, 1'b0, 8'hF0, 4'h9, 4'd0},
    '{1'b0, 1'b1, 1'b1, 1'b0, 8'h0A, 4'hF, 4'd6},
    '{1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 4'hF, 4'd7},
    '{1'b1, 1'b1, 1'b0, 1'b1, 8'hFF, 4'hC, 4'd0}
  };

  function automatic int expSample(input logic [1:0] c);
    return (c == 2'b00) ? 5 : (c == 2'b01) ? 4 : 3;
  endfunction
  function automatic int expRecov(input logic [1:0] c);
    return 4 - int'(c);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [7:0] v);
    @(negedge clk); cfgWe = 1'b1; cfgWdata = v;
    @(negedge clk); cfgWe = 1'b0;
  endtask

  task automatic runVec(input vec_t v);
    int c = int'(v.ch);
    logic [3:0] codes;
    int eS, eR, eLen, n, gap;
    logic strobe, other;
    writeCfg(v.regv);
    drv1En[c] = v.en;
    d0Timing[4*c +: 4] = v.d0;
    codes = (v.drv && v.en) ? v.regv[4*c +: 4] : v.d0;
    eS   = expSample(codes[3:2]);
    eR   = expRecov(codes[1:0]);
    eLen = (int'(v.k) > eS) ? int'(v.k) : eS;
    n = 0;
    while (!reqReady[c] && n < 20) begin @(negedge clk); n++; end
    iordy[c] = (v.k == 0);
    reqValid[c] = 1'b1; reqDrive[c] = v.drv; reqWrite[c] = v.wr;
    @(negedge clk);
    reqValid[c] = 1'b0;
    n = 0;
    forever begin
      strobe = v.wr ? iowN[c] : iorN[c];
      other  = v.wr ? iorN[c] : iowN[c];
      if (strobe || n > 40) break;
      n++;
      if (n >= int'(v.k)) iordy[c] = 1'b1;
      if (!other) check(1'b0, "R9 other strobe low", 0, 1);
      @(negedge clk);
    end
    // R3/R6 strobe width; R2 selects the codes
    check(n == eLen, "R3/R6/R2 strobe width", n, eLen);
    check(done[c] == 1'b1, "R7 done after release", int'(done[c]), 1);
    check(rsvdErr[c] == (codes[3:2] == 2'b11), "R4 reserved flag",
          int'(rsvdErr[c]), int'(codes[3:2] == 2'b11));
    gap = 0;
    for (int i = 0; i < 6; i++) begin
      if (reqReady[c] && gap == 0) gap = i + 1;
      if (i == 1) check(done[c] == 1'b0, "R7 done one cycle", int'(done[c]), 0);
      @(negedge clk);
    end
    check(gap == eR, "R5 recovery gap", gap, eR);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cfgRdata == 8'h00, "R1 reset value", int'(cfgRdata), 0);
    check(iorN == 2'b11 && iowN == 2'b11 && done == 2'b00, "R9 idle strobes",
          int'({iorN, iowN, done}), 8'b1111_0000 >> 2);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 2'b11, "R5 ready after reset", int'(reqReady), 3);
    @(negedge clk); cfgWe = 1'b1; cfgWdata = 8'h9C;
    @(negedge clk); cfgWe = 1'b0;
    check(cfgRdata == 8'h9C, "R1 write readback", int'(cfgRdata), 8'h9C);

    foreach (VECS[i]) runVec(VECS[i]);

    // R8 independence: channel 0 held busy, channel 1 still served
    writeCfg(8'h00);
    drv1En = 2'b11;
    iordy = 2'b00;
    reqValid[0] = 1'b1; reqDrive[0] = 1'b1; reqWrite[0] = 1'b0;
    @(negedge clk);
    reqValid[0] = 1'b0;
    check(reqReady[0] == 1'b0, "R8 busy channel not ready", int'(reqReady[0]), 0);
    check(reqReady[1] == 1'b1, "R8 other channel ready", int'(reqReady[1]), 1);
    reqValid[1] = 1'b1; reqDrive[1] = 1'b1; reqWrite[1] = 1'b1;
    @(negedge clk);
    reqValid[1] = 1'b0;
    check(iowN[1] == 1'b0 && iorN[0] == 1'b0, "R8 both strobes active",
          int'({iowN[1], iorN[0]}), 0);
    repeat (8) @(negedge clk);
    check(iorN[0] == 1'b0, "R6 strobe held while IORDY low", int'(iorN[0]), 0);
    iordy = 2'b11;
    @(negedge clk);
    check(done == 2'b11, "R7 both channels complete", int'(done), 3);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule